// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines three active-low reset requests into a single system-ready output. The three requests are a PLL start-up request, an asynchronous reset and a synchronous reset. Each one is judged against its own minimum low time. A request that is long enough holds system-ready low while it is held, and then for its own recovery delay after it is released. Each source has an independent recovery counter. Because system-ready stays low while any counter is running, the source with the longest remaining recovery decides when the system restarts.

All widths and delays are parameters counted in cycles of the reference clock. The defaults assume a 20 MHz reference:

| Source | Minimum low time | Recovery |
|---|---|---|
| PLL start-up | 80 cycles (4 µs) | 12240 cycles (612 µs) |
| Asynchronous reset | 33 cycles (1.65 µs) | 8200 cycles (410 µs) |
| Synchronous reset | 33 cycles (1.65 µs) | 18 cycles (0.9 µs) |

All three requests are measured through two-flop synchronizers. The asynchronous request also gates the output directly, so system-ready drops without waiting for a clock edge.

A request that is released before its minimum low time is treated as a glitch. It starts no recovery, but it sets a sticky warning flag. The next qualified PLL start-up request clears that flag.

Top module: `rst_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sys_ready` and `short_pulse` are low after that edge. At the first edge with `rst_n` high and all requests idle high, `sys_ready` goes high.
- R2: Whenever `arst_n` is low, `sys_ready` is low at once, with no clock edge needed.
- R3: Let F be the first edge that samples a request low, and let the request stay low for L consecutive edges. With L >= MIN (that source's minimum low time), `sys_ready` is low from edge F+MIN+2 onward.
- R4: Let R be the first edge that samples a qualified request high again. `sys_ready` returns high after edge R+REC+3, where REC is that source's recovery delay, provided no other source is busy.
- R5: When requests from several sources overlap, `sys_ready` is low over the union of their individual low windows. It therefore rises only when the last pending recovery has expired.
- R6: A PLL start-up or synchronous request with 1 <= L < MIN leaves `sys_ready` high at every edge. A short asynchronous request pulls `sys_ready` low only while `arst_n` is low.
- R7: A request with 1 <= L < MIN sets `short_pulse` after edge R+2. The flag then stays high until it is cleared.
- R8: `short_pulse` clears after edge F+MIN+1 of a PLL start-up request with L >= MIN. If a short-pulse event lands on the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer itself |
| pll_init_n | input | 1 | Active-low PLL start-up request |
| arst_n | input | 1 | Active-low asynchronous reset request |
| srst_n | input | 1 | Active-low synchronous reset request |
| sys_ready | output | 1 | High when the system may run |
| short_pulse | output | 1 | Sticky flag: a request was released before its minimum low time |

## Verification
Two events on the warning flag can fall on the same edge: the clear from a PLL start-up request reaching its minimum low time, and the set from a short request on another source being released. The bench places a two-cycle synchronous pulse so that its release is sampled on exactly the edge where the PLL request qualifies. It then expects the flag to remain high and to be cleared by a later lone PLL request. The recovery windows of different sources also collide, and the bench overlaps requests so that the later-released source has the shorter recovery. It then judges `sys_ready` edge by edge against the union of the computed windows.

// File: rtl/rsq_pkg.sv
// Package: shared source indices and per-source parameter selection for
// the reset sequencer. Assumes exactly three request sources.
package rsq_pkg;

    localparam int NUM_SRC = 3;

    typedef enum int {
        SRC_PLL  = 0,
        SRC_ARST = 1,
        SRC_SRST = 2
    } src_e;

    // Pick the value belonging to source idx out of three candidates.
    function automatic int src_param(input int idx, input int v_pll,
                                     input int v_arst, input int v_srst);
        if (idx == SRC_PLL)       return v_pll;
        else if (idx == SRC_ARST) return v_arst;
        else                      return v_srst;
    endfunction

endpackage

// File: rtl/rsq_sync.sv
// Two-flop synchronizer for an active-low request.
// Assumes the request idles high; both stages reset to the idle level.
module rsq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_n,
    output logic q_n
);

    logic meta_n;

    // Shift the raw level through two stages into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_n <= 1'b1;
            q_n    <= 1'b1;
        end else begin
            meta_n <= d_n;
            q_n    <= meta_n;
        end
    end

endmodule

// File: rtl/rsq_qual.sv
// Per-source qualifier: measures the synchronized low time of one request,
// holds busy once the low time reaches MIN_CYC, and runs a recovery count of
// REC_CYC cycles after a qualified release. A release before MIN_CYC raises
// short_evt for one cycle and starts no recovery.
// Assumes MIN_CYC >= 1 and a synchronized, idle-high input.
module rsq_qual #(
    parameter int MIN_CYC = 33,
    parameter int REC_CYC = 8200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    output logic busy,
    output logic qual_hit,
    output logic short_evt
);

    localparam int CW = $clog2(MIN_CYC + 2);
    localparam int RW = $clog2(REC_CYC + 2);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);
    localparam logic [RW-1:0] REC_V = RW'(REC_CYC);

    logic [CW-1:0] low_cnt;
    logic [RW-1:0] rec_cnt;
    logic          qualified;
    logic          release_ok;

    assign qualified  = (low_cnt == MIN_V);
    assign release_ok = lvl_n && qualified;
    assign short_evt  = lvl_n && (low_cnt != '0) && !qualified;
    assign qual_hit   = !lvl_n && (low_cnt == MIN_V - CW'(1));
    assign busy       = qualified || (rec_cnt != '0);

    // Count consecutive low cycles, saturating at the minimum width.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_cnt <= '0;
        else if (lvl_n)      low_cnt <= '0;
        else if (!qualified) low_cnt <= low_cnt + CW'(1);
    end

    // Load recovery on a qualified release, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                rec_cnt <= '0;
        else if (release_ok)       rec_cnt <= REC_V;
        else if (rec_cnt != '0)    rec_cnt <= rec_cnt - RW'(1);
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= MIN_V);  // R3
    AST_REC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_n && low_cnt == MIN_V) |=> rec_cnt == REC_V);  // R4
    AST_REC_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_cnt != '0 && low_cnt == '0) |=> rec_cnt == $past(rec_cnt) - RW'(1));  // R4
    AST_SHORT_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
        (short_evt && rec_cnt == '0) |=> rec_cnt == '0);  // R6

endmodule

// File: rtl/rsq_status.sv
// Merges the per-source busy and short-pulse indications into the
// registered ready level and the sticky short-pulse flag. A set on the same
// edge as a clear wins. Assumes clr is the PLL request's qualify strobe.
module rsq_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] busy,
    input  logic [N-1:0] short_evt,
    input  logic         clr,
    output logic         ready_q,
    output logic         flag_q
);

    logic short_any;

    assign short_any = |short_evt;

    // Ready only when no source is held or recovering.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= ~(|busy);
    end

    // Sticky warning: set by any short release, cleared by a PLL qualify.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (short_any) flag_q <= 1'b1;
        else if (clr)       flag_q <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);  // R7
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        short_any |=> flag_q);  // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !short_any) |=> !flag_q);  // R8

endmodule

// File: rtl/rst_seq.sv
// Top: three active-low requests (PLL start-up, asynchronous, synchronous)
// merged into one system-ready output. Every request is synchronized and
// qualified separately; the asynchronous request additionally gates the
// output combinationally. Delays are in reference-clock cycles.
module rst_seq #(
    parameter int PLL_MIN_CYC  = 80,
    parameter int PLL_REC_CYC  = 12240,
    parameter int ARST_MIN_CYC = 33,
    parameter int ARST_REC_CYC = 8200,
    parameter int SRST_MIN_CYC = 33,
    parameter int SRST_REC_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_init_n,
    input  logic arst_n,
    input  logic srst_n,
    output logic sys_ready,
    output logic short_pulse
);

    import rsq_pkg::*;

    logic [NUM_SRC-1:0] raw_n;
    logic [NUM_SRC-1:0] lvl_n;
    logic [NUM_SRC-1:0] busy;
    logic [NUM_SRC-1:0] qhit;
    logic [NUM_SRC-1:0] sevt;
    logic               ready_q;

    assign raw_n[SRC_PLL]  = pll_init_n;
    assign raw_n[SRC_ARST] = arst_n;
    assign raw_n[SRC_SRST] = srst_n;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int MINC = src_param(g, PLL_MIN_CYC, ARST_MIN_CYC, SRST_MIN_CYC);
        localparam int RECC = src_param(g, PLL_REC_CYC, ARST_REC_CYC, SRST_REC_CYC);

        rsq_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_n   (raw_n[g]),
            .q_n   (lvl_n[g])
        );

        rsq_qual #(
            .MIN_CYC (MINC),
            .REC_CYC (RECC)
        ) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_n     (lvl_n[g]),
            .busy      (busy[g]),
            .qual_hit  (qhit[g]),
            .short_evt (sevt[g])
        );

        AST_QHIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            qhit[g] |=> busy[g]);  // R3
    end

    rsq_status #(
        .N (NUM_SRC)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .short_evt (sevt),
        .clr       (qhit[SRC_PLL]),
        .ready_q   (ready_q),
        .flag_q    (short_pulse)
    );

    // Asynchronous request pulls the output low without a clock edge.
    assign sys_ready = ready_q & arst_n;

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|busy) |=> !sys_ready);  // R5

endmodule

// File: tb/tb_rst_seq.sv
`timescale 1ns/1ps
module tb_rst_seq;

    localparam int PMIN = 6;
    localparam int PREC = 30;
    localparam int AMIN = 4;
    localparam int AREC = 20;
    localparam int SMIN = 5;
    localparam int SREC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_n = 1'b1;
    logic ar_n = 1'b1;
    logic sr_n = 1'b1;
    logic sys_ready;
    logic short_pulse;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit exp_flag = 1'b0;
    bit done = 1'b0;

    int min_c[3] = '{PMIN, AMIN, SMIN};
    int rec_c[3] = '{PREC, AREC, SREC};

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_seq #(
        .PLL_MIN_CYC  (PMIN),
        .PLL_REC_CYC  (PREC),
        .ARST_MIN_CYC (AMIN),
        .ARST_REC_CYC (AREC),
        .SRST_MIN_CYC (SMIN),
        .SRST_REC_CYC (SREC)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pll_init_n  (pll_n),
        .arst_n      (ar_n),
        .srst_n      (sr_n),
        .sys_ready   (sys_ready),
        .short_pulse (short_pulse)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at edge %0d: actual %b expected %b", tag, what, cyc, act, exp);
        end
    endtask

    // One trial: per source an offset and a low length (0 = idle), judged edge by edge.
    task automatic run_trial(input int o0, input int l0, input int o1, input int l1,
                             input int o2, input int l2, input string tag);
        int off[3];
        int len[3];
        int f[3];
        int r[3];
        int base;
        int last;
        off = '{o0, o1, o2};
        len = '{l0, l1, l2};
        base = cyc + 1;
        last = base + 4;
        for (int i = 0; i < 3; i++) begin
            f[i] = base + off[i];
            r[i] = f[i] + len[i];
            if (len[i] > 0 && r[i] + rec_c[i] + 6 > last) last = r[i] + rec_c[i] + 6;
        end
        while (cyc < last) begin
            int e;
            bit lo[3];
            bit exp_rdy;
            bit do_set;
            bit do_clr;
            e = cyc + 1;
            for (int i = 0; i < 3; i++) lo[i] = (len[i] > 0) && e >= f[i] && e < r[i];
            pll_n = ~lo[0];
            ar_n  = ~lo[1];
            sr_n  = ~lo[2];
            #1;
            if (lo[1]) check(sys_ready, 1'b0, "R2", "sys_ready before edge");
            @(negedge clk);
            e = cyc;
            exp_rdy = 1'b1;
            do_set = 1'b0;
            do_clr = 1'b0;
            for (int i = 0; i < 3; i++) begin
                if (len[i] >= min_c[i]) begin
                    if (e >= f[i] + min_c[i] + 2 && e < r[i] + rec_c[i] + 3) exp_rdy = 1'b0;
                    if (i == 0 && e == f[i] + min_c[i] + 1) do_clr = 1'b1;
                end else if (len[i] > 0) begin
                    if (e == r[i] + 2) do_set = 1'b1;
                end
            end
            if (len[1] > 0 && e >= f[1] && e < r[1]) exp_rdy = 1'b0;
            if (do_set)      exp_flag = 1'b1;
            else if (do_clr) exp_flag = 1'b0;
            check(sys_ready, exp_rdy, tag, "sys_ready");
            check(short_pulse, exp_flag, "R7 R8", "short_pulse");
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then ready one edge after release
        repeat (3) @(negedge clk);
        check(sys_ready, 1'b0, "R1", "sys_ready in reset");
        check(short_pulse, 1'b0, "R1", "short_pulse in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(sys_ready, 1'b1, "R1", "sys_ready after reset");
        check(short_pulse, 1'b0, "R1", "short_pulse after reset");
        repeat (2) @(negedge clk);

        // Width sweeps per source around the minimum (R3 R4 valid, R6 R7 short)
        for (int l = 1; l <= PMIN + 2; l++)
            run_trial(0, l, 0, 0, 0, 0, (l >= PMIN) ? "R3 R4 pll" : "R6 R7 pll");
        for (int l = 1; l <= AMIN + 2; l++)
            run_trial(0, 0, 0, l, 0, 0, (l >= AMIN) ? "R3 R4 arst" : "R6 R7 arst");
        for (int l = 1; l <= SMIN + 2; l++)
            run_trial(0, 0, 0, 0, 0, l, (l >= SMIN) ? "R3 R4 srst" : "R6 R7 srst");

        // R5: overlaps where the longest remaining recovery governs
        run_trial(0, 8, 3, 5, 0, 0, "R5 pll+arst");
        run_trial(0, 6, 0, 0, 0, 20, "R5 srst released later");
        run_trial(2, 7, 0, 12, 5, 30, "R5 all three");
        run_trial(0, 0, 10, 6, 0, 14, "R5 arst+srst");

        // R8: short release lands on the PLL qualify edge; set wins
        run_trial(0, 0, 0, 0, 0, 2, "R7 set");
        run_trial(0, PMIN + 2, 0, 0, PMIN - 3, 2, "R8 same edge");
        run_trial(0, PMIN, 0, 0, 0, 0, "R8 clear");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule